// File: doc/BRIEF.md
# Multicart PRG Bank Switching Mapper

This block translates CPU addresses into program ROM addresses for a multi-game console cartridge. It snoops CPU writes in the upper part of the CPU address map. From those writes it keeps a 4-bit game bank and a 2-bit layout mode. For every access from $6000 up, it produces an 8 KiB page number that selects one of 64 pages, which makes 512 KiB of program ROM. It also tells the video side which nametable mirroring to use.

The CPU address space from $6000 to $FFFF is split into five 8 KiB windows: $6000, $8000, $A000, $C000 and $E000. The layout mode decides which page each window shows:
- Two modes present one linear 32 KiB block at $8000–$FFFF.
- The other two modes split that range into two fixed 16 KiB halves.

Each page number is formed by ORing the game bank, shifted into page bits 5:2, with a per-mode, per-window constant. Register updates land on the clock edge that samples the write strobe. Address translation is combinational.

Top module: `mcart_prg_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank register clears to 0 and the mode to 1. Afterwards $6000 maps to page 0x23, $8000/$A000/$C000/$E000 map to pages 0x00/0x01/0x02/0x03, and `mirror_horiz` is 0.
- R2: A write (`cpu_wr`=1) to $6000–$7FFF sets the mode to {data bit 4, data bit 1}. Mode bit 1 is the upper bit.
- R3: A write to $8000–$FFFF loads the bank from data bits 3:0. The bank occupies page bits 5:2, and data bits 7:4 never reach the bank.
- R4: A write to $C000–$DFFF also replaces mode bit 1 with data bit 4, and mode bit 0 is kept.
- R5: A write to $8000–$BFFF or $E000–$FFFF leaves the mode unchanged, whatever the data.
- R6: In mode 0 the windows $6000, $8000, $A000, $C000 and $E000 map to pages bank|0x2F, bank|0x00, bank|0x01, bank|0x0E and bank|0x0F.
- R7: In mode 1 they map to bank|0x23, bank|0x00, bank|0x01, bank|0x02 and bank|0x03.
- R8: In mode 2 they map to bank|0x2F, bank|0x02, bank|0x03, bank|0x0E and bank|0x0F.
- R9: Mode 3 uses the page mapping of mode 1 and drives `mirror_horiz`=1 (horizontal). Modes 0–2 drive `mirror_horiz`=0 (vertical).
- R10: For addresses at or above $6000, `prg_sel`=1 and `prg_addr` = {page, cpu_addr[12:0]}. Below $6000, `prg_sel`=0 and `prg_addr`=0.
- R11: With `cpu_wr`=0, or with a write below $6000, neither the bank nor the mode changes.
- R12: A write changes the outputs only after the rising clock edge that samples it. Before that edge the old mapping is still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per cycle it is high |
| prg_addr | output | 19 | Program ROM address {page, offset} |
| prg_sel | output | 1 | High when the CPU address is at or above $6000 |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The embedded assertions check, on every cycle, how each write window updates the mode and the bank, and that idle cycles and writes below $6000 leave both registers alone. They also check the offset pass-through and zeroing around the $6000 boundary, the linear window order in modes 1 and 3, and the fixed upper page bits of the split modes. The full page tables for all four modes, each with several bank values, can only be shown by the bench's scenarios. The same holds for the mirroring choice, data bits 7:4 being dropped from the bank, and the old mapping staying visible until the clock edge.

// File: rtl/mcart_pkg.sv
// Shared definitions for the multicart program-ROM mapper.
// Assumes the CPU address map places the switchable windows from $6000 up.
package mcart_pkg;
    localparam int WIN_N = 5;  // $6000, $8000, $A000, $C000, $E000

    typedef enum logic [1:0] {
        MODE_SPLIT_A = 2'd0,  // split halves, low half pages 0/1
        MODE_LINEAR  = 2'd1,  // linear 32 KiB, vertical mirroring
        MODE_SPLIT_B = 2'd2,  // split halves, low half pages 2/3
        MODE_LIN_HOR = 2'd3   // linear 32 KiB, horizontal mirroring
    } map_mode_e;
endpackage

// File: rtl/mcart_bank_regs.sv
// Holds the game bank and layout mode written by the CPU.
// Assumes one write per cycle that cpu_wr is high; reset is synchronous, active low.
module mcart_bank_regs
    import mcart_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [BANK_W-1:0] bank_q,
    output map_mode_e         mode_q
);
    localparam int MODE_HI_BIT = 4;
    localparam int MODE_LO_BIT = 1;

    logic [2:0] win;
    logic       hit_lo, hit_hi, hit_c;

    // Decode which 8 KiB write window the address falls in.
    always_comb begin
        win    = addr[ADDR_W-1 -: 3];
        hit_lo = (win == 3'b011);
        hit_hi = win[2];
        hit_c  = (win == 3'b110);
    end

    // Register update on CPU writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            mode_q <= MODE_LINEAR;
        end else if (wr) begin
            if (hit_lo) begin
                mode_q <= map_mode_e'({data[MODE_HI_BIT], data[MODE_LO_BIT]});
            end else if (hit_hi) begin
                bank_q <= data[BANK_W-1:0];
                if (hit_c) begin
                    mode_q <= map_mode_e'({data[MODE_HI_BIT], mode_q[0]});
                end
            end
        end
    end

    // R2: a low-window write sets both mode bits from the data.
    a_r2_mode_low_win: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) && $past(addr[ADDR_W-1 -: 3]) == 3'b011
        |-> mode_q == {$past(data[MODE_HI_BIT]), $past(data[MODE_LO_BIT])});

    // R4: a $C000 write replaces only mode bit 1.
    a_r4_mode_c_win: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) && $past(addr[ADDR_W-1 -: 3]) == 3'b110
        |-> mode_q[1] == $past(data[MODE_HI_BIT]) && mode_q[0] == $past(mode_q[0]));

    // R3: an upper-window write loads the bank.
    a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) && $past(addr[ADDR_W-1])
        |-> bank_q == $past(data[BANK_W-1:0]));

    // R11: no write strobe or an address below $6000 keeps both registers.
    a_r11_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (!$past(wr) || $past(addr[ADDR_W-1 -: 3]) < 3'b011)
        |-> $stable(bank_q) && $stable(mode_q));

    // R5: upper writes outside $C000-$DFFF keep the mode.
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) && $past(addr[ADDR_W-1]) && $past(addr[ADDR_W-1 -: 3]) != 3'b110
        |-> $stable(mode_q));
endmodule

// File: rtl/mcart_page_gen.sv
// Forms the page number of each CPU window and picks the one addressed.
// Assumes win_sel holds CPU address bits 15:13; values below 3 produce page 0.
module mcart_page_gen
    import mcart_pkg::*;
#(
    parameter int PAGE_W = 6,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  map_mode_e         mode,
    input  logic [2:0]        win_sel,
    output logic [PAGE_W-1:0] page,
    output logic              mirror_horiz
);
    localparam int SHIFT = PAGE_W - BANK_W;

    // Per-mode OR constant for a window index (0 = $6000 .. 4 = $E000).
    function automatic logic [PAGE_W-1:0] win_mask(input map_mode_e m, input int idx);
        logic [1:0]        low;
        logic [PAGE_W-1:0] hi;
        low = (idx == 0) ? 2'd3 : 2'(idx - 1);
        case (m)
            MODE_SPLIT_A: hi = (idx == 0) ? PAGE_W'(6'h2C) : (idx <= 2) ? PAGE_W'(6'h00) : PAGE_W'(6'h0C);
            MODE_SPLIT_B: hi = (idx == 0) ? PAGE_W'(6'h2E) : (idx <= 2) ? PAGE_W'(6'h02) : PAGE_W'(6'h0E);
            default:      hi = (idx == 0) ? PAGE_W'(6'h20) : PAGE_W'(6'h00);
        endcase
        return hi | PAGE_W'(low);
    endfunction

    logic [PAGE_W-1:0] bank_page;
    logic [PAGE_W-1:0] page_w [WIN_N];

    assign bank_page = {bank, SHIFT'(0)};

    // One page former per CPU window.
    for (genvar gi = 0; gi < WIN_N; gi++) begin : g_win
        assign page_w[gi] = bank_page | win_mask(mode, gi);
    end

    // Select the addressed window's page and the mirroring.
    always_comb begin
        page = '0;
        for (int i = 0; i < WIN_N; i++) begin
            if (win_sel == 3'(i + 3)) page = page_w[i];
        end
        mirror_horiz = (mode == MODE_LIN_HOR);
    end

    // R6/R8: split modes keep the upper half on pages x|0x0E/0x0F.
    a_r8_split_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[0] |-> page_w[3][3:1] == 3'b111 && page_w[4][3:1] == 3'b111);

    // R8: mode 2 lifts the lower half by two pages.
    a_r8_split_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_SPLIT_B |-> page_w[1][1] && page_w[2][1]);
endmodule

// File: rtl/mcart_prg_mapper.sv
// Top of the multicart program-ROM mapper: snoops CPU writes, keeps bank and
// mode, and translates CPU addresses at or above $6000 into ROM addresses.
// Assumes a synchronous active-low reset; translation is combinational.
module mcart_prg_mapper
    import mcart_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4,
    parameter int PAGE_W = 6,
    parameter int OFF_W  = 13,
    parameter int PRG_W  = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    output logic [PRG_W-1:0]  prg_addr,
    output logic              prg_sel,
    output logic              mirror_horiz
);
    logic [BANK_W-1:0] bank_q;
    map_mode_e         mode_q;
    logic [PAGE_W-1:0] page;
    logic [2:0]        win_sel;

    assign win_sel = cpu_addr[ADDR_W-1 -: 3];

    mcart_bank_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr), .data(cpu_data),
        .bank_q(bank_q), .mode_q(mode_q)
    );

    mcart_page_gen #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) pages_i (
        .clk(clk), .rst_n(rst_n), .bank(bank_q), .mode(mode_q), .win_sel(win_sel),
        .page(page), .mirror_horiz(mirror_horiz)
    );

    // Drive the ROM address only inside the mapped range.
    always_comb begin
        prg_sel  = (win_sel >= 3'b011);
        prg_addr = prg_sel ? {page, cpu_addr[OFF_W-1:0]} : '0;
    end

    // R10: below $6000 the ROM address is zero.
    a_r10_below_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr < ADDR_W'(16'h6000) |-> prg_addr == '0);

    // R10: mapped accesses pass the in-page offset through.
    a_r10_offset: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr >= ADDR_W'(16'h6000) |-> prg_sel && prg_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    // R7: linear modes order $8000-$FFFF as bank page plus window number.
    a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[0] && cpu_addr[ADDR_W-1]
        |-> prg_addr[PRG_W-1 -: PAGE_W] == {bank_q, cpu_addr[ADDR_W-2 -: 2]});
endmodule

// File: tb/mcart_prg_mapper_tb_top.sv
// Directed bench for the multicart program-ROM mapper.
module mcart_prg_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [18:0] prg_addr;
    logic        prg_sel;
    logic        mirror_horiz;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of bank and mode, updated from the requirements.
    logic [3:0] m_bank;
    logic [1:0] m_mode;

    always #4 clk = ~clk;  // 125 MHz

    mcart_prg_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .prg_addr(prg_addr), .prg_sel(prg_sel), .mirror_horiz(mirror_horiz)
    );

    // Page tables of R6, R7, R8 and R9; win 3..7 are CPU address bits 15:13.
    function automatic logic [5:0] exp_page(input logic [1:0] md, input logic [3:0] bk, input logic [2:0] win);
        logic [5:0] c;
        case (md)
            2'd0:    case (win) 3'd3: c = 6'h2F; 3'd4: c = 6'h00; 3'd5: c = 6'h01; 3'd6: c = 6'h0E; default: c = 6'h0F; endcase
            2'd2:    case (win) 3'd3: c = 6'h2F; 3'd4: c = 6'h02; 3'd5: c = 6'h03; 3'd6: c = 6'h0E; default: c = 6'h0F; endcase
            default: case (win) 3'd3: c = 6'h23; 3'd4: c = 6'h00; 3'd5: c = 6'h01; 3'd6: c = 6'h02; default: c = 6'h03; endcase
        endcase
        return {bk, 2'b00} | c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one address between edges and check the translated address.
    task automatic probe(input string tag, input logic [15:0] a, input logic [5:0] pg);
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_addr = a;
        #1;
        check(tag, {13'd0, prg_addr}, {13'd0, pg, a[12:0]});
    endtask

    // One CPU write; the model follows R2 to R5 and R11.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a >= 16'h6000 && a < 16'h8000) m_mode = {d[4], d[1]};
        else if (a >= 16'h8000) begin
            m_bank = d[3:0];
            if (a >= 16'hC000 && a < 16'hE000) m_mode[1] = d[4];
        end
    endtask

    // Check all five windows and the mirroring against the model.
    task automatic sweep(input string tag);
        for (int w = 3; w < 8; w++) begin
            logic [15:0] a;
            a = {3'(w), 13'h0A5 + 13'(w)};
            probe(tag, a, exp_page(m_mode, m_bank, 3'(w)));
        end
        #1;
        check({tag, " mirror R9"}, {31'd0, mirror_horiz}, {31'd0, m_mode == 2'd3});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_bank = 4'd0;
        m_mode = 2'd1;
        probe("R1 reset $6000", 16'h6000, 6'h23);
        probe("R1 reset $8000", 16'h8000, 6'h00);
        probe("R1 reset $E123", 16'hE123, 6'h03);
        check("R1 reset mirror", {31'd0, mirror_horiz}, 32'd0);
    endtask

    task automatic t_low_window();
        cpu_write(16'h6000, 8'h10);  // mode 2
        sweep("R2 mode2 R8");
        cpu_write(16'h7FFF, 8'h02);  // mode 1
        sweep("R2 mode1 R7");
        cpu_write(16'h6ABC, 8'hED);  // bits 4,1 = 0,0 -> mode 0
        sweep("R2 mode0 R6");
        cpu_write(16'h7001, 8'h12);  // mode 3
        sweep("R2 mode3 R9");
    endtask

    task automatic t_bank();
        cpu_write(16'h8000, 8'h0A);
        sweep("R3 bank A");
        cpu_write(16'hA123, 8'hF5);  // upper nibble dropped, mode stays 3 (R5)
        sweep("R3 R5 bank 5 high data");
        check("R5 mode kept", {31'd0, mirror_horiz}, 32'd1);
        cpu_write(16'hFFFF, 8'h0F);
        sweep("R3 R5 bank F");
    endtask

    task automatic t_c_window();
        cpu_write(16'hC000, 8'h05);  // mode 3 -> 1, bank 5
        sweep("R4 C000 clear bit1");
        cpu_write(16'h6000, 8'h00);  // mode 0
        cpu_write(16'hDFFF, 8'h1C);  // mode 0 -> 2, bank C
        sweep("R4 DFFF set bit1");
    endtask

    task automatic t_ignored();
        logic [5:0] pg;
        pg = exp_page(m_mode, m_bank, 3'd4);
        @(negedge clk);
        cpu_addr = 16'h5FFF; cpu_data = 8'hFF; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_addr = 16'h0000;
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_wr = 1'b0;  // strobe low at an upper address
        @(negedge clk);
        cpu_addr = 16'hC000;
        @(negedge clk);
        probe("R11 ignored writes $8000", 16'h8000, pg);
        sweep("R11 ignored writes all");
        @(negedge clk);
        cpu_addr = 16'h5FFF;
        #1;
        check("R10 $5FFF sel", {31'd0, prg_sel}, 32'd0);
        check("R10 $5FFF addr", {13'd0, prg_addr}, 32'd0);
        cpu_addr = 16'h6000;
        #1;
        check("R10 $6000 sel", {31'd0, prg_sel}, 32'd1);
    endtask

    task automatic t_timing();
        logic [5:0] old_pg;
        old_pg = exp_page(m_mode, m_bank, 3'd4);
        @(negedge clk);
        cpu_addr = 16'h8010; cpu_data = 8'h07; cpu_wr = 1'b1;
        #1;
        check("R12 before edge", {13'd0, prg_addr}, {13'd0, old_pg, 13'h0010});
        @(negedge clk);
        cpu_wr = 1'b0;
        m_bank = 4'h7;
        #1;
        check("R12 after edge", {13'd0, prg_addr}, {13'd0, exp_page(m_mode, 4'h7, 3'd4), 13'h0010});
    endtask

    task automatic t_mode_sweep();
        for (int md = 0; md < 4; md++) begin
            cpu_write(16'h6000, {3'b0, 1'(md >> 1), 2'b0, 1'(md), 1'b0});
            for (int bk = 0; bk < 16; bk += 5) begin
                cpu_write(16'hA000, 8'(bk));
                sweep($sformatf("R6 R7 R8 R9 mode%0d bank%0d", md, bk));
            end
        end
    endtask

    initial begin
        t_reset();
        t_low_window();
        t_bank();
        t_c_window();
        t_ignored();
        t_timing();
        t_mode_sweep();
        t_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule